// File: doc/BRIEF.md
# Flash command interface controller

This block sits on the device side of a byte-wide flash memory that has a protected boot region. It decodes command bytes written on a simple bus, steps a small write state machine through read-array, read-status and program-setup modes, and keeps an 8-bit status word with a ready flag, a supply-low flag and a program-error flag. The storage is a register array held inside the block. A program can only clear bits: the new byte is ANDed with the stored byte.

A host programs a byte in four steps. It writes the setup code, then writes the data byte to the target address, then polls the status word until the ready flag returns, and finally writes the read-array code. Bytes in the boot region can only be programmed while one of two high-voltage enable flags is held. A locked attempt leaves the array unchanged and raises the error flag. A low programming supply raises a sticky flag, and that flag refuses every later program until the host clears it. Output data is captured only on a read strobe, so the status word refreshes on each strobe.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in read-array mode, every array byte reads FFh, no status flag is set, and `rdata` is 00h.
- R2: A write of 40h arms program setup. The next write starts a program of `addr` that stores (old AND `wdata`). After that write the block is in read-status mode.
- R3: A write of FFh selects read-array mode. Every bus write made while a program is busy is ignored.
- R4: The status word is {ready, 0, 0, error, supply_low, 0, 0, 0}, with bit 7 = ready, bit 4 = program error and bit 3 = supply low. Ready is 0 for exactly BUSY_CYC cycles after the data write of an accepted program.
- R5: A program whose data would need to turn a stored 0 into 1 sets bit 4. The bits that can be cleared are still cleared.
- R6: A program attempted while `vpp_low` is high sets bit 3 and leaves the array unchanged. While bit 3 is set, every program attempt is refused.
- R7: Bit 4 remains set across later successful programs until a clear command.
- R8: A write of 50h outside program setup clears bits 3 and 4 and leaves the array and the mode unchanged.
- R9: The boot region is the BOOT_SIZE addresses at the top of the array (BOOT_TOP=1) or at the bottom (BOOT_TOP=0). A program there with neither `hv_rst` nor `hv_oe` high sets bit 4 and leaves the byte unchanged.
- R10: With `hv_rst` or `hv_oe` high, a boot-region program succeeds. If both enables go low while that program is busy, it is aborted with bit 4 set and no change to the byte.
- R11: `rdata` changes only on a cycle with `rd_stb` high. It then loads the array byte at `addr` in read-array mode, and the status word otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | One-cycle bus write strobe |
| addr | input | ADDR_W | Byte address for writes and reads |
| wdata | input | 8 | Command or data byte |
| rd_stb | input | 1 | Read strobe that refreshes `rdata` |
| hv_rst | input | 1 | High-voltage enable on the reset path |
| hv_oe | input | 1 | High-voltage enable on the output-enable path |
| vpp_low | input | 1 | Programming supply below threshold |
| rdata | output | 8 | Captured array byte or status word |

## Verification
The hardest case to reach is the loss of the boot enable while a program is already counting down. This case only differs from a normal locked attempt in its timing. The bench raises `hv_rst`, issues setup and data writes to a boot address, and drops the enable on the next falling edge, while the busy counter is still running. It then checks that the byte still reads FFh and that bit 4 is set. Sticky-flag ordering is reached by chaining programs without clears in between, and by retrying after the supply flag has returned to normal.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W    = 5,
  parameter int BUSY_CYC  = 4,
  parameter int BOOT_SIZE = 8,
  parameter bit BOOT_TOP  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd_stb,
  input  logic              hv_rst,
  input  logic              hv_oe,
  input  logic              vpp_low,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_SETUP} mode_t;

  mode_t             mode;
  logic [7:0]        mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] p_addr;
  logic [7:0]        p_data;
  logic              p_boot, p_fail;
  logic              sr3, sr4;

  wire busy     = (cnt != '0);
  wire hv_ok    = hv_rst | hv_oe;
  wire [ADDR_W-1:0] rel = BOOT_TOP ? ~addr : addr;
  wire boot_w   = ({1'b0, rel} < (ADDR_W+1)'(BOOT_SIZE));
  wire lost_hv  = p_boot & ~hv_ok;
  wire [7:0] merged = mem[p_addr] & p_data;
  wire clr_cmd  = !busy && we && mode != M_SETUP && wdata == 8'h50;
  wire [7:0] status = {~busy, 2'b00, sr4, sr3, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= M_ARRAY;
      cnt    <= '0;
      p_addr <= '0;
      p_data <= '0;
      p_boot <= 1'b0;
      p_fail <= 1'b0;
      sr3    <= 1'b0;
      sr4    <= 1'b0;
      rdata  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (busy) begin
        cnt <= cnt - 1'b1;
        if (lost_hv) begin
          p_fail <= 1'b1;
          sr4    <= 1'b1;
        end
        if (cnt == CNT_W'(1) && !p_fail && !lost_hv) begin
          mem[p_addr] <= merged;
          if (merged != p_data) sr4 <= 1'b1;
        end
      end else if (we) begin
        if (mode == M_SETUP) begin
          mode <= M_STATUS;
          if (sr3 || vpp_low) sr3 <= 1'b1;
          else if (boot_w && !hv_ok) sr4 <= 1'b1;
          else begin
            cnt    <= CNT_W'(BUSY_CYC);
            p_addr <= addr;
            p_data <= wdata;
            p_boot <= boot_w;
            p_fail <= 1'b0;
          end
        end else begin
          case (wdata)
            8'hFF: mode <= M_ARRAY;
            8'h40: mode <= M_SETUP;
            8'h50: begin
              sr3 <= 1'b0;
              sr4 <= 1'b0;
            end
            default: ;
          endcase
        end
      end
      if (rd_stb) rdata <= (mode == M_ARRAY) ? mem[addr] : status;
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt == $past(cnt) - 1'b1);

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> mode == $past(mode));

  // R2
  setup_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && we && mode == M_SETUP) |=> mode == M_STATUS);

  // R6
  sr3_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && we && mode == M_SETUP && sr3) |=> (!busy && sr3));

  // R8
  clear_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (!sr3 && !sr4));

  // R7
  sr4_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr4 && !clr_cmd) |=> sr4);
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int AW = 5;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, rd_stb = 1'b0;
  logic hv_rst = 1'b0, hv_oe = 1'b0, vpp_low = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, got;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .BUSY_CYC(4), .BOOT_SIZE(8), .BOOT_TOP(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rd_stb(rd_stb),
    .hv_rst(hv_rst), .hv_oe(hv_oe), .vpp_low(vpp_low), .rdata(rdata));

  // {addr, data, flags(hv_rst=04 hv_oe=02 vpp_low=01), status, byte}
  localparam logic [39:0] VEC [9] = '{
    40'h02_A5_00_80_A5,  // R2
    40'h02_F0_00_90_A0,  // R5
    40'h02_20_00_80_20,  // R2
    40'h1A_12_00_90_FF,  // R9
    40'h1A_12_04_80_12,  // R10
    40'h1B_34_02_80_34,  // R10
    40'h05_00_01_88_FF,  // R6
    40'h17_0F_00_80_0F,  // R9 last unprotected
    40'h18_0F_00_90_FF   // R9 first protected
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); rd_stb = 1'b1; addr = a;
    @(negedge clk); rd_stb = 1'b0; v = rdata;
  endtask

  task automatic wait_ready();
    logic [7:0] v;
    for (int i = 0; i < 40; i++) begin
      rd(0, v);
      if (v[7]) break;
    end
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input logic [2:0] f);
    hv_rst = f[2]; hv_oe = f[1]; vpp_low = f[0];
    wr(0, 8'h40);
    wr(a, d);
    vpp_low = 1'b0;
    wait_ready();
    hv_rst = 1'b0; hv_oe = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rdata after reset", rdata, 8'h00);
    rd(3, got); chk("R1 array erased", got, 8'hFF);
    rd(31, got); chk("R1 array erased top", got, 8'hFF);

    for (int i = 0; i < 9; i++) begin
      wr(0, 8'h50);
      prog(VEC[i][39:32], VEC[i][31:24], VEC[i][18:16]);
      rd(0, got); chk($sformatf("R4 table status %0d", i), got, VEC[i][15:8]);
      wr(0, 8'hFF);
      rd(VEC[i][39:32], got); chk($sformatf("R2 table byte %0d", i), got, VEC[i][7:0]);
    end

    // R7: error bit stays through a good program
    wr(0, 8'h50);
    prog(5'h1C, 8'h00, 3'b000);
    prog(5'h0A, 8'h55, 3'b000);
    rd(0, got); chk("R7 sticky error", got, 8'h90);
    wr(0, 8'hFF);
    rd(5'h0A, got); chk("R7 good program landed", got, 8'h55);
    // R8: clear leaves mode and array alone
    wr(0, 8'h50);
    rd(5'h0A, got); chk("R8 clear keeps array mode", got, 8'h55);
    wr(0, 8'h40); wr(0, 8'hFF); wait_ready();
    rd(0, got); chk("R8 flags cleared", got, 8'h80);

    // R6: supply flag blocks later attempts
    wr(0, 8'h50);
    prog(5'h0B, 8'h66, 3'b001);
    prog(5'h0B, 8'h66, 3'b000);
    rd(0, got); chk("R6 refused while set", got, 8'h88);
    wr(0, 8'hFF);
    rd(5'h0B, got); chk("R6 array untouched", got, 8'hFF);
    wr(0, 8'h50);
    prog(5'h0B, 8'h66, 3'b000);
    rd(0, got); chk("R6 retry after clear", got, 8'h80);

    // R4/R3/R11: busy window, ignored write, latched read
    wr(0, 8'h50);
    wr(0, 8'h40);
    wr(5'h0C, 8'h77);
    wr(0, 8'hFF);
    rd(5'h0B, got); chk("R3 write ignored while busy", got, 8'h00);
    repeat (8) @(negedge clk);
    chk("R11 rdata held without strobe", rdata, 8'h00);
    rd(0, got); chk("R4 ready after busy", got, 8'h80);
    wr(0, 8'hFF);
    rd(5'h0C, got); chk("R2 busy program landed", got, 8'h77);

    // R10: enable dropped mid-operation
    wr(0, 8'h50);
    hv_rst = 1'b1;
    wr(0, 8'h40);
    wr(5'h1D, 8'h00);
    hv_rst = 1'b0;
    wait_ready();
    rd(0, got); chk("R10 abort flagged", got, 8'h90);
    wr(0, 8'hFF);
    rd(5'h1D, got); chk("R10 abort leaves byte", got, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule